// File: doc/BRIEF.md
# Serial Character Transmitter with Holding and Line-Idle Flags

This block turns parallel words into asynchronous serial characters on a single output line. A word written by the host lands in a one-entry holding register. From there it moves into a shift register at the next baud pulse once the shifter is free. The shifter drives a low start bit, then the payload with the least significant bit first, then an optional parity bit, and finally a high stop bit. It moves to the next bit only on a baud pulse, so the line rate is set entirely by whoever generates that pulse.

Two flags tell the host where things stand. `hold_empty` shows that the holding register can accept the next word. `line_done` shows that the shifter has finished and nothing is waiting. The host refills the holding register as soon as `hold_empty` rises, which happens while the current character is still shifting. Characters therefore follow each other with no idle gap. `line_done` is the flag to wait on before the line may be switched off or reconfigured.

The character length can be short (`WORD_W-1` bit slots) or long (`WORD_W` bit slots). When parity is on, it takes the last slot and the payload is one bit shorter. The format inputs are captured together with each word as it enters the shifter.

Top module: `sertx_top`

## Requirements
- R1: During and right after reset, `txd` is 1, `hold_empty` is 1 and `line_done` is 1.
- R2: A write (`wr_en` high for one cycle) while `hold_empty` is 1 stores `wr_data`. From the next cycle `hold_empty` is 0 and `line_done` is 0.
- R3: A write while `hold_empty` is 0 is ignored. The word already held is the one transmitted later.
- R4: A held word moves into the shifter only in a cycle where `baud_tick` is 1 and the shifter is idle or in its stop bit. In the next cycle `hold_empty` is 1 again. With no `baud_tick`, a held word stays held and the line stays high.
- R5: A character is a start bit of 0, then the payload with bit 0 first, then a stop bit of 1. Each bit lasts from one `baud_tick` to the next one.
- R6: `len_long`=0 gives `WORD_W-1` bit slots between start and stop, and `len_long`=1 gives `WORD_W` slots. With `par_en`=1 the last slot carries parity and the payload is one bit shorter. Bits of `wr_data` beyond the payload are not sent.
- R7: With `par_odd`=0 the parity bit makes the number of ones across payload and parity even. With `par_odd`=1 it makes that number odd.
- R8: `line_done` is 1 exactly when the shifter is idle and the holding register is empty. It rises only after the stop bit of the last pending character has ended.
- R9: If a word is held when a stop bit ends, its start bit follows at once with no idle bit between, and `line_done` stays 0.
- R10: `par_en`, `par_odd` and `len_long` are sampled when a word enters the shifter. Changing them mid-character affects only later characters.
- R11: Between characters `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse that advances the line by one bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | WORD_W | Word to send; payload taken from bit 0 up |
| par_en | input | 1 | 1 puts a parity bit in the last slot |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| len_long | input | 1 | 1 selects WORD_W slots, 0 selects WORD_W-1 |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can take a word |
| line_done | output | 1 | Nothing shifting and nothing held |

## Verification
Every 9-bit value is sent under all six format combinations: parity off, even or odd, each in short and long length. This separates errors in payload order and slot count from errors in the parity polarity. The bits above the payload also take every value, which shows that they never reach the line. A separate back-to-back pattern refills the holding register during a character, attempts an overwrite while it is full, and changes the format mid-character. This tells a gapless hand-over apart from one that inserts an idle bit or sends the wrong word. It also shows whether the format is captured at load or read live. Holding a word with no baud pulse shows that loading waits for the pulse.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // number of bit slots between start and stop for a given length select
  function automatic int unsigned slot_count(input logic long_fmt, input int unsigned word_w);
    return long_fmt ? word_w : word_w - 1;
  endfunction

  // running parity: fold one more sent bit into the accumulator
  function automatic logic par_step(input logic acc, input logic bit_in);
    return acc ^ bit_in;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] data
);

  logic              full_q;
  logic [WORD_W-1:0] data_q;
  logic              accept;

  // a write only lands when the slot is free; otherwise it is dropped
  assign accept = wr_en && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              len_long,
  output logic              take,
  output logic              txd,
  output logic              busy
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  tx_state_e         state_q;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_q;
  logic              acc_q;
  logic              pen_q;
  logic              ready;
  logic              at_last;
  logic              par_slot;
  logic [CNT_W-1:0]  last_new;

  assign ready    = (state_q == ST_IDLE) || (state_q == ST_STOP);
  assign take     = baud_tick && hold_full && ready;
  assign at_last  = (cnt_q == last_q);
  assign par_slot = pen_q && at_last;
  assign last_new = CNT_W'(slot_count(len_long, WORD_W) - 1);
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START: txd = 1'b0;
      ST_BITS:  txd = par_slot ? acc_q : shreg_q[0];
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      acc_q   <= 1'b0;
      pen_q   <= 1'b0;
    end else if (take) begin
      state_q <= ST_START;
      shreg_q <= hold_data;
      cnt_q   <= '0;
      last_q  <= last_new;
      acc_q   <= par_odd;
      pen_q   <= par_en;
    end else if (baud_tick) begin
      case (state_q)
        ST_START: state_q <= ST_BITS;
        ST_BITS: begin
          acc_q   <= par_step(acc_q, shreg_q[0]);
          shreg_q <= shreg_q >> 1;
          cnt_q   <= cnt_q + 1'b1;
          if (at_last) state_q <= ST_STOP;
        end
        ST_STOP: state_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              len_long,
  output logic              txd,
  output logic              hold_empty,
  output logic              line_done
);

  logic              load_evt;
  logic              hold_full;
  logic [WORD_W-1:0] hold_data;
  logic              busy;

  sertx_hold #(.WORD_W(WORD_W)) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load_evt),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_shift #(.WORD_W(WORD_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .len_long  (len_long),
    .take      (load_evt),
    .txd       (txd),
    .busy      (busy)
  );

  assign hold_empty = !hold_full;
  assign line_done  = !busy && !hold_full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_en,
  input logic txd,
  input logic hold_empty,
  input logic line_done,
  input logic load_evt
);

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_empty) |=> !hold_empty) else $error("AST_WRITE_FILLS"); // R2

  AST_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !load_evt) |=> !hold_empty) else $error("AST_FULL_KEPT"); // R3

  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (baud_tick && !hold_empty)) else $error("AST_LOAD_ON_TICK"); // R4

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!txd && hold_empty && !line_done)) else $error("AST_START_AFTER_LOAD"); // R9

  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd)) else $error("AST_LINE_STEADY"); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (txd && hold_empty)) else $error("AST_DONE_IDLE"); // R8

  AST_DONE_RISE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_done) |-> $past(baud_tick)) else $error("AST_DONE_RISE_TICK"); // R8

endmodule

bind sertx_top sertx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .wr_en      (wr_en),
  .txd        (txd),
  .hold_empty (hold_empty),
  .line_done  (line_done),
  .load_evt   (load_evt)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  localparam int unsigned W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         baud_tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         par_en = 1'b0;
  logic         par_odd = 1'b0;
  logic         len_long = 1'b0;
  logic         txd;
  logic         hold_empty;
  logic         line_done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sertx_top #(.WORD_W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .len_long   (len_long),
    .txd        (txd),
    .hold_empty (hold_empty),
    .line_done  (line_done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int slots_of(input logic lg);
    return lg ? W : W - 1;
  endfunction

  function automatic logic exp_bit(input logic [W-1:0] d, input logic pe, input logic po,
                                   input logic lg, input int i);
    int payload;
    logic p;
    payload = slots_of(lg) - (pe ? 1 : 0);
    if (i < payload) return d[i];
    p = po;
    for (int k = 0; k < payload; k++) p = p ^ d[k];
    return p;
  endfunction

  task automatic tick();
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic write(input logic [W-1:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // shifter already in start bit; walk the slots and the stop bit
  task automatic body(input logic [W-1:0] d, input logic pe, input logic po, input logic lg);
    int payload;
    payload = slots_of(lg) - (pe ? 1 : 0);
    for (int i = 0; i < slots_of(lg); i++) begin
      tick();
      chk((i < payload) ? "R5 payload bit" : "R7 parity bit", txd, exp_bit(d, pe, po, lg, i));
      chk("R8 busy during slots", line_done, 1'b0);
    end
    tick();
    chk("R6 stop bit after slot count", txd, 1'b1);
    chk("R8 busy in stop", line_done, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 hold_empty in reset", hold_empty, 1'b1);
    chk("R1 line_done in reset", line_done, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd after reset", txd, 1'b1);
    chk("R1 hold_empty after reset", hold_empty, 1'b1);
    chk("R1 line_done after reset", line_done, 1'b1);

    // held word waits for a baud pulse
    write(9'h055);
    repeat (5) @(negedge clk);
    chk("R4 no load without tick", hold_empty, 1'b0);
    chk("R4 line high without tick", txd, 1'b1);
    tick();
    chk("R4 start after tick", txd, 1'b0);
    chk("R4 hold freed", hold_empty, 1'b1);
    body(9'h055, 1'b0, 1'b0, 1'b0);
    tick();
    chk("R8 done after stop", line_done, 1'b1);

    // sweep every word under every format
    for (int cfg = 0; cfg < 6; cfg++) begin
      par_en   = (cfg >= 2);
      par_odd  = (cfg >= 4);
      len_long = cfg[0];
      for (int d = 0; d < (1 << W); d++) begin
        write(W'(d));
        chk("R2 hold_empty after write", hold_empty, 1'b0);
        chk("R2 line_done after write", line_done, 1'b0);
        chk("R11 idle line high", txd, 1'b1);
        tick();
        chk("R5 start bit", txd, 1'b0);
        chk("R4 hold_empty after load", hold_empty, 1'b1);
        body(W'(d), par_en, par_odd, len_long);
        tick();
        chk("R8 done after last stop", line_done, 1'b1);
        chk("R11 line high after stop", txd, 1'b1);
      end
    end

    // back-to-back, overwrite attempt, mid-character format change
    par_en = 1'b1; par_odd = 1'b0; len_long = 1'b1;
    write(9'h1A5);
    tick();
    chk("R5 start of first", txd, 1'b0);
    par_en = 1'b0; par_odd = 1'b1; len_long = 1'b0;
    write(9'h03C);
    chk("R2 refill during character", hold_empty, 1'b0);
    write(9'h0FF);
    chk("R3 overwrite ignored flag", hold_empty, 1'b0);
    body(9'h1A5, 1'b1, 1'b0, 1'b1);
    tick();
    chk("R9 start follows stop", txd, 1'b0);
    chk("R9 no line_done between", line_done, 1'b0);
    chk("R4 hold freed at hand-over", hold_empty, 1'b1);
    body(9'h03C, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R8 done after pair", line_done, 1'b1);
    chk("R10 R11 line high at end", txd, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule